// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it takes sole control of the clock-enable, the command strobes, the bank select and the row address, and plays out the fixed start-up script. The script starts with a long stabilization hold with clock-enable low. It then wakes the device with a NOP and closes every bank. Next come the two mode-register loads, the first of which turns the DLL on and the second resets it. The script then closes every bank again, issues two auto refreshes, and makes a final mode-register load that leaves the DLL reset bit clear.

Every wait is counted in controller clock cycles, and parameters derive the counts from the clock frequency and from nanosecond or microsecond timings. A NOP stays on the command bus through every wait. The ready flag rises only after two conditions both hold: the final mode load has had its settle time, and the DLL has had its full lock interval since its reset. The ready flag then stays high, and the bus stays idle until a normal controller takes over.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, the outputs are cke=0, command NOP ({cs_n,ras_n,cas_n,we_n}=0111), ba=0, addr=0 and init_done=0.
- R2: For the first T_PWR = PWR_US*CLK_MHZ cycles after reset release (cycles 0 to T_PWR-1), cke stays 0 and the command is NOP.
- R3: In cycle T_PWR, cke goes to 1 with a NOP on the bus, and cke stays at 1 from then on.
- R4: PRECHARGE ALL (command 0010 with addr bit 10 = 1, ba=0) is issued in cycle T_PWR+1. A second PRECHARGE ALL is issued T_MRD cycles after the DLL-reset mode load.
- R5: T_RP cycles after the first precharge, the extended mode register is loaded: command 0000, ba=2'b01, addr=EMR_VAL.
- R6: T_MRD cycles after the extended load, the base mode register is loaded: command 0000, ba=2'b00, addr=MR_VAL with bit 8 (DLL reset) set.
- R7: Two AUTO REFRESH commands (0001, ba=0, addr=0) are issued. The first comes T_RP cycles after the second precharge and the second comes T_RFC cycles after the first.
- R8: T_RFC cycles after the second refresh, the base mode register is loaded again: command 0000, ba=0, addr=MR_VAL with bit 8 cleared.
- R9: init_done rises in cycle max(final load + T_MRD, DLL-reset load + DLL_CYC) and stays high. The command stays NOP once init_done is high.
- R10: In every cycle that is not one of the command cycles named above, the command is NOP and ba and addr are zero.
- R11: Wait times are derived as T_RP = max(2, ceil(TRP_NS*CLK_MHZ/1000)), T_RFC = max(2, ceil(TRFC_NS*CLK_MHZ/1000)) and T_MRD = max(2, TMRD_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ROW_W | Row / mode-register address |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
Two timers can end in the same cycle: the settle time after the final mode load and the DLL lock interval counted from the DLL-reset load. The bench runs three copies of the block side by side, each with a different lock length. In one copy the lock interval ends late, in another it ends early, and in the third both timers expire in exactly the same cycle. A behavioural model computes the cycle of each command from the requirements and compares every output of all three copies on every clock. A ready flag that arrives one cycle early or late, or a command that appears twice, therefore shows up in the exact cycle where it goes wrong.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ  = 125,
  parameter int PWR_US   = 200,
  parameter int TRP_NS   = 20,
  parameter int TMRD_CYC = 2,
  parameter int TRFC_NS  = 75,
  parameter int DLL_CYC  = 200,
  parameter int ROW_W    = 13,
  parameter logic [ROW_W-1:0] MR_VAL  = 'h032,
  parameter logic [ROW_W-1:0] EMR_VAL = 'h000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);
  localparam int T_PWR  = PWR_US * CLK_MHZ;
  localparam int RP_RAW = (TRP_NS * CLK_MHZ + 999) / 1000;
  localparam int RF_RAW = (TRFC_NS * CLK_MHZ + 999) / 1000;
  localparam int T_RP   = (RP_RAW < 2) ? 2 : RP_RAW;
  localparam int T_RFC  = (RF_RAW < 2) ? 2 : RF_RAW;
  localparam int T_MRD  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int CW     = $clog2(T_PWR + T_RP + T_RFC + T_MRD + 2);
  localparam int DW     = $clog2(DLL_CYC + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;

  typedef enum logic [3:0] {
    S_PWR, S_WAKE, S_PRE1, S_EMR, S_MRR, S_PRE2,
    S_REF1, S_REF2, S_MRF, S_LOCK, S_DONE
  } st_t;

  st_t            state;
  logic [CW-1:0]  cnt, gap;
  logic [DW-1:0]  dll;
  logic           last, issue, lock_ok;
  logic [3:0]     cmd;

  always_comb begin
    case (state)
      S_PWR:                gap = CW'(T_PWR);
      S_PRE1, S_PRE2:       gap = CW'(T_RP);
      S_EMR, S_MRR, S_MRF:  gap = CW'(T_MRD);
      S_REF1, S_REF2:       gap = CW'(T_RFC);
      default:              gap = CW'(1);
    endcase
  end

  assign last    = (cnt == gap - CW'(1));
  assign lock_ok = (dll >= DW'(DLL_CYC - 1));
  assign issue   = (cnt == '0) && (state inside {S_PRE1, S_EMR, S_MRR, S_PRE2, S_REF1, S_REF2, S_MRF});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PWR;
      cnt   <= '0;
      dll   <= '0;
    end else begin
      if (state == S_MRR && cnt == '0) dll <= DW'(1);
      else if (dll != '0 && dll < DW'(DLL_CYC)) dll <= dll + DW'(1);

      if (state == S_LOCK) begin
        if (lock_ok) state <= S_DONE;
      end else if (state != S_DONE) begin
        if (last) begin
          cnt <= '0;
          if (state == S_MRF) state <= lock_ok ? S_DONE : S_LOCK;
          else                state <= st_t'(4'(state) + 4'd1);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    if (issue) begin
      case (state)
        S_PRE1, S_PRE2: begin cmd = C_PRE; addr[10] = 1'b1; end
        S_EMR:          begin cmd = C_LMR; ba = 2'b01; addr = EMR_VAL; end
        S_MRR:          begin cmd = C_LMR; addr = MR_VAL; addr[8] = 1'b1; end
        S_MRF:          begin cmd = C_LMR; addr = MR_VAL; addr[8] = 1'b0; end
        S_REF1, S_REF2: cmd = C_REF;
        default:        cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (state != S_PWR);
  assign init_done = (state == S_DONE);

  AST_CKE_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == C_NOP)); // R2
  AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == C_PRE) |-> addr[10]); // R4
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} != C_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == C_NOP)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ({cs_n, ras_n, cas_n, we_n} == C_NOP) && cke); // R9
  AST_DLL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (dll >= DW'(DLL_CYC))); // R9
endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;
  localparam int W = 13;
  localparam logic [W-1:0] MRV = 13'h032;
  localparam logic [W-1:0] EMV = 13'h002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic       cke_a, cs_a, ra_a, ca_a, we_a, dn_a;
  logic [1:0] ba_a;
  logic [W-1:0] ad_a;
  logic       cke_b, cs_b, ra_b, ca_b, we_b, dn_b;
  logic [1:0] ba_b;
  logic [W-1:0] ad_b;
  logic       cke_c, cs_c, ra_c, ca_c, we_c, dn_c;
  logic [1:0] ba_c;
  logic [W-1:0] ad_c;

  ddr_init_seq #(.PWR_US(2), .DLL_CYC(200), .MR_VAL(MRV), .EMR_VAL(EMV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke_a), .cs_n(cs_a), .ras_n(ra_a), .cas_n(ca_a),
    .we_n(we_a), .ba(ba_a), .addr(ad_a), .init_done(dn_a));
  ddr_init_seq #(.PWR_US(1), .DLL_CYC(27), .MR_VAL(MRV), .EMR_VAL(EMV)) dut_j (
    .clk(clk), .rst_n(rst_n), .cke(cke_b), .cs_n(cs_b), .ras_n(ra_b), .cas_n(ca_b),
    .we_n(we_b), .ba(ba_b), .addr(ad_b), .init_done(dn_b));
  ddr_init_seq #(.PWR_US(1), .DLL_CYC(10), .TRFC_NS(120), .MR_VAL(MRV), .EMR_VAL(EMV)) dut_k (
    .clk(clk), .rst_n(rst_n), .cke(cke_c), .cs_n(cs_c), .ras_n(ra_c), .cas_n(ca_c),
    .we_n(we_c), .ba(ba_c), .addr(ad_c), .init_done(dn_c));

  // expected vector {cke, cmd[3:0], ba[1:0], addr[12:0], done} and requirement tag
  function automatic logic [20:0] model(int c, int pwr, int rfc, int dll, output string tag);
    int rp = 3, mrd = 2;
    int tn, tp1, te, tm, tp2, tr1, tr2, tf, td;
    logic [3:0] cmd = 4'b0111;
    logic [1:0] b = 2'b00;
    logic [W-1:0] a = '0;
    tn = pwr; tp1 = tn + 1; te = tp1 + rp; tm = te + mrd; tp2 = tm + mrd;
    tr1 = tp2 + rp; tr2 = tr1 + rfc; tf = tr2 + rfc;
    td = (tf + mrd > tm + dll) ? tf + mrd : tm + dll;
    tag = "R10";
    if (c < pwr) tag = "R2";
    else if (c == tn) tag = "R3";
    else if (c == tp1 || c == tp2) begin tag = "R4"; cmd = 4'b0010; a[10] = 1'b1; end
    else if (c == te) begin tag = "R5"; cmd = 4'b0000; b = 2'b01; a = EMV; end
    else if (c == tm) begin tag = "R6"; cmd = 4'b0000; a = MRV | 13'h100; end
    else if (c == tr1 || c == tr2) begin tag = "R7"; cmd = 4'b0001; end
    else if (c == tf) begin tag = "R8"; cmd = 4'b0000; a = MRV & ~13'h100; end
    else if (c >= td - 1) tag = "R9";
    return {(c >= pwr), cmd, b, a, (c >= td)};
  endfunction

  task automatic cmp(string who, string tag, int c, logic [20:0] act, logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d: got %h expected %h", tag, who, c, act, exp);
    end
  endtask

  initial begin
    string tg;
    logic [20:0] e;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("dut_i", "R1", -1, {cke_a, cs_a, ra_a, ca_a, we_a, ba_a, ad_a, dn_a}, {1'b0, 4'b0111, 2'b00, 13'h0, 1'b0});
    cmp("dut_j", "R1", -1, {cke_b, cs_b, ra_b, ca_b, we_b, ba_b, ad_b, dn_b}, {1'b0, 4'b0111, 2'b00, 13'h0, 1'b0});
    rst_n = 1'b1;
    for (int c = 0; c < 520; c++) begin
      #1;
      // R11: derived waits T_RP=3, T_MRD=2, T_RFC=10 (15 for 120 ns)
      e = model(c, 250, 10, 200, tg);
      cmp("dut_i", tg, c, {cke_a, cs_a, ra_a, ca_a, we_a, ba_a, ad_a, dn_a}, e);
      e = model(c, 125, 10, 27, tg);
      cmp("dut_j", tg, c, {cke_b, cs_b, ra_b, ca_b, we_b, ba_b, ad_b, dn_b}, e);
      e = model(c, 125, 15, 10, tg);
      cmp("dut_k", tg, c, {cke_c, cs_c, ra_c, ca_c, we_c, ba_c, ad_c, dn_c}, e);
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule